// File: doc/BRIEF.md
# Fall-Through Sample FIFO for a Converter Output Path

This block sits between the result stage of an analog-to-digital converter and the tri-state output register that drives the pins. It has two modes. In direct mode the converter result goes straight to the output. In FIFO mode every completed conversion is stored automatically, up to sixteen 18-bit words. Each stored word holds the 16 data bits, a second copy of the data MSB and the overflow flag.

The FIFO is first-word-fall-through. The oldest stored word is always present on the output without a read. A host steps through the stored words with rising edges of a read line, and watches two status pins that give the fill level. The end-of-conversion strobe and the read line are asynchronous. Each is brought into the system clock domain through a synchronizer chain and then edge-detected. A store happens on the falling edge of end-of-conversion. Driving the mode input low while the read line is also low empties the FIFO at any time.

Top module: `fwft_sample_fifo`

## Requirements
- R1: After the synchronous reset, the status pins read empty (`stat_hi`=0, `stat_lo`=1). In FIFO mode `out_word` reads all zeros.
- R2: With `fifo_mode` low and `rd_line` high, `out_word` equals {`conv_ovf`, `conv_data[15]`, `conv_data`} (bit 17 overflow, bit 16 MSB copy, bits 15:0 data). End-of-conversion edges in this state store nothing.
- R3: With `fifo_mode` high, each falling edge of `eoc` stores one word, whatever the level of `rd_line`.
- R4: A word stored into an empty FIFO appears on `out_word` with no read.
- R5: The status pins {`stat_hi`,`stat_lo`} encode the fill level as follows: 0 words = 01, 1 to 7 words = 00, 8 to 15 words = 10, 16 words = 11.
- R6: A store attempted while 16 words are held is discarded. No discarded word ever reaches the output.
- R7: Each rising edge of `rd_line` moves the output to the next stored word while two or more words are held. With one word held, the next falling edge of `rd_line` sets the status to empty.
- R8: A read while the FIFO is empty leaves `out_word` unchanged.
- R9: `fifo_mode` low together with `rd_line` low empties the FIFO.
- R10: A store and a read step in the same clock cycle, with 2 to 15 words held, leave the word count unchanged and keep the words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = FIFO in the path, 0 = direct |
| rd_line | input | 1 | Asynchronous read line; rising edges step the output |
| eoc | input | 1 | Asynchronous end-of-conversion; falling edge stores a word |
| conv_data | input | 16 | Converter result |
| conv_ovf | input | 1 | Converter overflow flag |
| out_word | output | 18 | {overflow, MSB copy, data} toward the output register |
| stat_hi | output | 1 | Fill status, high bit |
| stat_lo | output | 1 | Fill status, low bit |

## Verification
A single store into an empty FIFO, with the read line held low, shows that the output falls through and that stores do not depend on the read line. A sixteen-word fill with a seventeenth store, followed by fifteen read pulses and a final falling edge, walks every status code boundary (7/8 words and 15/16 words). It also shows that the discarded word never appears on the output. Coincident store and read edges show that the count holds and the order is kept. A direct-mode pass shows pass-through, and a direct-mode pass with the read line low shows the flush.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;

    localparam int SMP_W  = 16;
    localparam int WORD_W = SMP_W + 2;

    typedef struct packed {
        logic             ovf;
        logic             msb_dup;
        logic [SMP_W-1:0] data;
    } sample_word_t;

    typedef enum logic [1:0] {
        FILL_PART  = 2'b00,
        FILL_NONE  = 2'b01,
        FILL_HALF  = 2'b10,
        FILL_ALL   = 2'b11
    } fill_code_t;

    function automatic sample_word_t make_word(input logic [SMP_W-1:0] d,
                                               input logic o);
        sample_word_t w;
        w.ovf     = o;
        w.msb_dup = d[SMP_W-1];
        w.data    = d;
        return w;
    endfunction

endpackage

// File: rtl/sync_delay.sv
module sync_delay #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic prev_level
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_level <= RST_VAL;
        else     prev_level <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/fwft_store.sv
module fwft_store
    import fwft_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic         step,
    input  logic         retire,
    input  sample_word_t in_word,
    output sample_word_t head_word,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    sample_word_t     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             is_full, is_empty, do_push, do_adv, do_last, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        is_full  = (count == CNT_W'(DEPTH));
        is_empty = (count == '0);
        do_push  = push && !is_full;
        do_adv   = step && (count > CNT_W'(1));
        do_last  = retire && (count == CNT_W'(1));
        do_pop   = do_adv || do_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= in_word;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_push && (is_empty || do_last))
                rd_ptr <= wr_ptr;
            else if (do_adv)
                rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_word = mem[rd_ptr];
endmodule

// File: rtl/fill_status.sv
module fill_status
    import fwft_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    output fill_code_t       code
);
    localparam int HALF = DEPTH / 2;

    always_comb begin
        if (count == '0)                 code = FILL_NONE;
        else if (count == CNT_W'(DEPTH)) code = FILL_ALL;
        else if (count >= CNT_W'(HALF))  code = FILL_HALF;
        else                             code = FILL_PART;
    end
endmodule

// File: rtl/fwft_sample_fifo.sv
module fwft_sample_fifo
    import fwft_fifo_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_mode,
    input  logic              rd_line,
    input  logic              eoc,
    input  logic [SMP_W-1:0]  conv_data,
    input  logic              conv_ovf,
    output logic [WORD_W-1:0] out_word,
    output logic              stat_hi,
    output logic              stat_lo
);
    logic rd_lvl, rd_prev, eoc_lvl, eoc_prev;
    logic rd_rise, rd_fall, wr_en, flush;
    logic [CNT_W-1:0] fill_count;
    sample_word_t cur_word, head_word;
    fill_code_t   code;

    sync_delay #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
        .clk(clk), .rst(rst), .async_in(rd_line),
        .level(rd_lvl), .prev_level(rd_prev)
    );

    sync_delay #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_eoc_sync (
        .clk(clk), .rst(rst), .async_in(eoc),
        .level(eoc_lvl), .prev_level(eoc_prev)
    );

    always_comb begin
        rd_rise  = fifo_mode && rd_lvl && !rd_prev;
        rd_fall  = fifo_mode && !rd_lvl && rd_prev;
        wr_en    = fifo_mode && !eoc_lvl && eoc_prev;
        flush    = !fifo_mode && !rd_lvl;
        cur_word = make_word(conv_data, conv_ovf);
    end

    fwft_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .push(wr_en), .step(rd_rise), .retire(rd_fall),
        .in_word(cur_word), .head_word(head_word), .count(fill_count)
    );

    fill_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
        .count(fill_count), .code(code)
    );

    assign out_word = fifo_mode ? head_word : cur_word;
    assign stat_hi  = code[1];
    assign stat_lo  = code[0];
endmodule

// File: rtl/fwft_fifo_checker.sv
module fwft_fifo_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_mode,
    input logic             rd_lvl,
    input logic             wr_en,
    input logic             rd_rise,
    input logic             flush,
    input logic [CNT_W-1:0] fill_count,
    input logic [17:0]      out_word,
    input logic             stat_hi,
    input logic             stat_lo
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fill_count == '0)); // R1

    AST_DIRECT_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode && rd_lvl) |=> $stable(fill_count)); // R2

    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (rst)
        (fill_count == '0) |-> ({stat_hi, stat_lo} == 2'b01)); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CNT_W'(DEPTH)); // R6

    AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (fill_count == CNT_W'(DEPTH) && wr_en && !rd_rise && !flush)
        |=> (fill_count == CNT_W'(DEPTH))); // R6

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fifo_mode && fill_count == '0 && !wr_en) ##1 fifo_mode
        |-> $stable(out_word)); // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode && !rd_lvl) |=> (fill_count == '0)); // R9

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_rise && fill_count >= CNT_W'(2)
         && fill_count < CNT_W'(DEPTH)) |=> $stable(fill_count)); // R10
endmodule

bind fwft_sample_fifo fwft_fifo_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .rd_lvl(rd_lvl),
    .wr_en(wr_en), .rd_rise(rd_rise), .flush(flush),
    .fill_count(fill_count), .out_word(out_word),
    .stat_hi(stat_hi), .stat_lo(stat_lo)
);

// File: tb/test_fwft_sample_fifo.sv
module test_fwft_sample_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_mode = 1'b1;
    logic        rd_line = 1'b1;
    logic        eoc = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_ovf = 1'b0;
    logic [17:0] out_word;
    logic        stat_hi, stat_lo;

    int checks = 0;
    int fails  = 0;
    logic [15:0] words [16];

    always #2 clk = ~clk;

    fwft_sample_fifo i_fwft_sample_fifo (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .rd_line(rd_line),
        .eoc(eoc), .conv_data(conv_data), .conv_ovf(conv_ovf),
        .out_word(out_word), .stat_hi(stat_hi), .stat_lo(stat_lo)
    );

    function automatic logic [17:0] mk(input logic [15:0] d, input logic o);
        return {o, d[15], d};
    endfunction

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_stat(input string req, input logic [1:0] exp);
        chk(req, {16'b0, stat_hi, stat_lo}, {16'b0, exp});
    endtask

    task automatic store(input logic [15:0] d, input logic o);
        conv_data = d; conv_ovf = o; eoc = 1'b1;
        settle(5);
        eoc = 1'b0;
        settle(6);
    endtask

    task automatic rd_pulse();
        rd_line = 1'b0; settle(6);
        rd_line = 1'b1; settle(6);
    endtask

    task automatic t_reset();
        settle(4);
        rst = 1'b0;
        settle(2);
        chk_stat("R1 status", 2'b01);
        chk("R1 out", out_word, 18'h0);
    endtask

    task automatic t_direct();
        fifo_mode = 1'b0; rd_line = 1'b1;
        conv_data = 16'hA5C3; conv_ovf = 1'b1;
        settle(2);
        chk("R2 pass-through", out_word, mk(16'hA5C3, 1'b1));
        conv_data = 16'h0042; conv_ovf = 1'b0;
        settle(1);
        chk("R2 pass-through", out_word, mk(16'h0042, 1'b0));
        eoc = 1'b1; settle(5); eoc = 1'b0; settle(6);
        fifo_mode = 1'b1;
        settle(2);
        chk_stat("R2 no store", 2'b01);
        chk("R2 no store out", out_word, 18'h0);
    endtask

    task automatic t_fill_drain();
        rd_line = 1'b0; settle(6);
        words[0] = 16'h1234;
        store(words[0], 1'b0);
        chk("R3 R4 fall-through", out_word, mk(16'h1234, 1'b0));
        chk_stat("R5 one word", 2'b00);
        rd_line = 1'b1; settle(6);
        chk("R7 single word no step", out_word, mk(16'h1234, 1'b0));
        for (int i = 1; i < 16; i++) begin
            words[i] = 16'h1000 + 16'(i);
            store(words[i], 1'b0);
            if (i == 6)  chk_stat("R5 seven words", 2'b00);
            if (i == 7)  chk_stat("R5 eight words", 2'b10);
            if (i == 14) chk_stat("R5 fifteen words", 2'b10);
        end
        chk_stat("R5 full", 2'b11);
        store(16'hDEAD, 1'b1);
        chk_stat("R6 still full", 2'b11);
        chk("R6 head kept", out_word, mk(16'h1234, 1'b0));
        for (int k = 1; k < 16; k++) begin
            rd_pulse();
            chk("R7 step", out_word, mk(words[k], 1'b0));
            if (k == 1) chk_stat("R5 after one read", 2'b10);
            if (k == 8) chk_stat("R5 eight left", 2'b10);
            if (k == 9) chk_stat("R5 seven left", 2'b00);
        end
        chk_stat("R7 last word held", 2'b00);
        rd_line = 1'b0; settle(6);
        chk_stat("R7 falling edge empties", 2'b01);
        chk("R6 dropped word absent", out_word, mk(words[15], 1'b0));
        rd_line = 1'b1; settle(6);
        rd_pulse();
        chk("R8 empty read holds", out_word, mk(words[15], 1'b0));
        chk_stat("R8 still empty", 2'b01);
    endtask

    task automatic t_same_cycle();
        store(16'h8001, 1'b0);
        chk("R4 refill fall-through", out_word, mk(16'h8001, 1'b0));
        store(16'h0002, 1'b1);
        conv_data = 16'h0003; conv_ovf = 1'b0; eoc = 1'b1;
        rd_line = 1'b0;
        settle(6);
        rd_line = 1'b1; eoc = 1'b0;
        settle(6);
        chk_stat("R10 count kept", 2'b00);
        chk("R10 advanced", out_word, mk(16'h0002, 1'b1));
        rd_pulse();
        chk("R10 order kept", out_word, mk(16'h0003, 1'b0));
        rd_line = 1'b0; settle(6);
        chk_stat("R10 drained", 2'b01);
        rd_line = 1'b1; settle(6);
    endtask

    task automatic t_flush();
        store(16'h0100, 1'b0);
        store(16'h0200, 1'b0);
        store(16'h0300, 1'b0);
        chk("R4 head after empty", out_word, mk(16'h0100, 1'b0));
        chk_stat("R9 three words", 2'b00);
        fifo_mode = 1'b0; settle(2);
        rd_line = 1'b0; settle(6);
        chk_stat("R9 flushed", 2'b01);
        rd_line = 1'b1; settle(6);
        fifo_mode = 1'b1; settle(2);
        chk_stat("R9 empty after flush", 2'b01);
        store(16'h0777, 1'b0);
        chk("R9 new head after flush", out_word, mk(16'h0777, 1'b0));
        chk_stat("R9 one word", 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_direct();
        t_fill_drain();
        t_same_cycle();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule